// File: doc/BRIEF.md
# Bus condition and timeout monitor

This block watches the clock and data lines of a two-wire controller/target bus from a free-running reference clock. It first brings both lines into its own clock domain, then detects START, Repeated START and STOP conditions. From the time both lines have stayed high since a STOP, it grades the quiet bus at three nested levels: free, available and idle. Each level carries its own permission. Available allows a target to request a START for an in-band interrupt or a controller handoff. Idle allows a hot-join attempt.

Two no-edge watchdogs support recovery on the target side. The first watches a transaction: if neither line moves for a programmed time, the block decides that the bus cannot be in a high-data-rate mode and holds that verdict until the next START or STOP. The second watches a read: if the clock line stops moving while the target is sending data, the block tells the target to abandon the read and release the data line.

All thresholds are counts of reference-clock cycles, supplied on configuration ports so that one build can serve any reference frequency. The outputs are plain level flags and one-cycle pulses. The block has no data stream, so it needs no handshake.

Top module: `bus_cond_monitor`

## Requirements
- R1: `start_p` pulses for one cycle when SDA falls while SCL stays high. `stop_p` pulses for one cycle when SDA rises while SCL stays high. A line change sampled at reference edge k shows at the pulses in the cycle after edge k+1, because the inputs pass through 2 synchronizer flops before detection.
- R2: `bus_free` is high when the last condition seen was a STOP and both lines have been high, with no edge on either line, for at least `free_lim` cycles. It drops in the cycle after any START, any line edge, or either line going low.
- R3: `bus_avail` is high when `bus_free` holds and the same high-run count has reached `avail_lim`. `ibi_ok` is high whenever `bus_avail` is high, and also during the one-cycle pulse of a plain START.
- R4: `bus_idle` is high when `bus_avail` holds and the high-run count has reached the idle limit: `idle_lim_long` when `idle_short_sel` is 0, and `idle_lim_short` when it is 1. `hotjoin_ok` equals `bus_idle`.
- R5: While reset is asserted, all pulses and flags are low. The line history is taken as both lines high and the last condition is taken as a STOP. After release, the grading levels therefore rise once the thresholds are reached, with no STOP on the lines.
- R6: A START whose last condition was a STOP (or reset) is plain: `start_p` is high and `rep_start_p` is low. A START seen without an intervening STOP raises both `start_p` and `rep_start_p`.
- R7: `sdr_mode` is set once neither line has changed for `quiet_lim` cycles while a transaction is open, meaning no STOP has been seen since the last START. It stays set through other edges and is cleared only in the cycle after a START or a STOP.
- R8: `read_abort` is high while `read_active` is high and no SCL edge has been seen for at least `read_lim` cycles since `read_active` rose or since the last SCL edge. It falls as soon as `read_active` drops, and the cycle after an SCL edge.
- R9: Every run counter saturates at 2^CW-1 and does not wrap. A limit equal to 2^CW-1 is therefore reached and then held for as long as the condition lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Raw clock line level |
| sda_i | input | 1 | Raw data line level |
| read_active | input | 1 | Target is currently sending read data |
| free_lim | input | CW | Cycles of high lines after a STOP for bus free |
| avail_lim | input | CW | Cycles of high lines for bus available |
| idle_lim_long | input | CW | Idle threshold, normal setting |
| idle_lim_short | input | CW | Idle threshold, reduced setting |
| idle_short_sel | input | 1 | 1 selects the reduced idle threshold |
| quiet_lim | input | CW | No-edge cycles inside a transaction before the mode verdict |
| read_lim | input | CW | No-SCL-edge cycles during a read before abort |
| start_p | output | 1 | START or Repeated START pulse |
| rep_start_p | output | 1 | Repeated START pulse |
| stop_p | output | 1 | STOP pulse |
| bus_free | output | 1 | Bus free level |
| bus_avail | output | 1 | Bus available level |
| bus_idle | output | 1 | Bus idle level |
| ibi_ok | output | 1 | In-band interrupt request permitted |
| hotjoin_ok | output | 1 | Hot-join request permitted |
| sdr_mode | output | 1 | Quiet-line verdict: bus is not in a high-data-rate mode |
| read_abort | output | 1 | Abandon the read and release SDA |

## Verification
The bench builds the monitor with CW set to 8, so every counter can reach its ceiling of 255 within a short run. This lets a limit of 255 exercise saturation without wrap-around. Small thresholds (4, 10, 30, 60, 25 and 15 cycles) place each grading step, both idle settings, the mode verdict and the read abort within a few dozen cycles. This is short enough to drive full transfers, repeated STARTs, a stalled read and a quiet stretch inside a transaction, all in one run.

// File: rtl/bcm_pkg.sv
package bcm_pkg;
  typedef struct packed {
    logic scl;
    logic sda;
  } bcm_lines_t;
endpackage

// File: rtl/bcm_line_sync.sv
module bcm_line_sync
  import bcm_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  bcm_lines_t raw,
  output bcm_lines_t now,
  output bcm_lines_t prev
);
  localparam int LAST = STAGES - 1;

  bcm_lines_t pipe [STAGES];

  // Stage chain; all flops reset to "both lines high".
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= '1;
        else        pipe[0] <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[i] <= '1;
        else        pipe[i] <= pipe[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else        prev <= pipe[LAST];
  end

  assign now = pipe[LAST];
endmodule

// File: rtl/bcm_run_timer.sv
module bcm_run_timer #(
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] lim,
  output logic [CW-1:0] cnt,
  output logic          reached
);
  localparam logic [CW-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (cnt != TOP) cnt <= cnt + 1'b1;
  end

  assign reached = (cnt >= lim);

  p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
  p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cnt == TOP) |=> (cnt == TOP));
endmodule

// File: rtl/bus_cond_monitor.sv
module bus_cond_monitor
  import bcm_pkg::*;
#(
  parameter int CW          = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          read_active,
  input  logic [CW-1:0] free_lim,
  input  logic [CW-1:0] avail_lim,
  input  logic [CW-1:0] idle_lim_long,
  input  logic [CW-1:0] idle_lim_short,
  input  logic          idle_short_sel,
  input  logic [CW-1:0] quiet_lim,
  input  logic [CW-1:0] read_lim,
  output logic          start_p,
  output logic          rep_start_p,
  output logic          stop_p,
  output logic          bus_free,
  output logic          bus_avail,
  output logic          bus_idle,
  output logic          ibi_ok,
  output logic          hotjoin_ok,
  output logic          sdr_mode,
  output logic          read_abort
);
  bcm_lines_t raw, now, prev;
  logic any_edge, scl_edge, both_hi;
  logic stopped;
  logic [CW-1:0] hi_cnt, quiet_cnt, rd_cnt;
  logic hi_free, quiet_hit, rd_hit;
  logic [CW-1:0] idle_lim;

  assign raw = '{scl: scl_i, sda: sda_i};

  bcm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(raw), .now(now), .prev(prev)
  );

  assign any_edge = (now != prev);
  assign scl_edge = (now.scl != prev.scl);
  assign both_hi  = now.scl & now.sda;

  // Conditions: data changes while clock held high
  assign start_p     = prev.scl & now.scl & prev.sda & ~now.sda;
  assign stop_p      = prev.scl & now.scl & ~prev.sda & now.sda;
  assign rep_start_p = start_p & ~stopped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stopped <= 1'b1;
    else if (start_p) stopped <= 1'b0;
    else if (stop_p)  stopped <= 1'b1;
  end

  // High-run timer feeds all three grading levels
  bcm_run_timer #(.CW(CW)) u_hi (
    .clk(clk), .rst_n(rst_n), .clr(any_edge | ~both_hi),
    .lim(free_lim), .cnt(hi_cnt), .reached(hi_free)
  );

  assign idle_lim   = idle_short_sel ? idle_lim_short : idle_lim_long;
  assign bus_free   = stopped & hi_free;
  assign bus_avail  = bus_free & (hi_cnt >= avail_lim);
  assign bus_idle   = bus_avail & (hi_cnt >= idle_lim);
  assign ibi_ok     = bus_avail | (start_p & stopped);
  assign hotjoin_ok = bus_idle;

  // Quiet-line watchdog, only inside an open transaction
  bcm_run_timer #(.CW(CW)) u_quiet (
    .clk(clk), .rst_n(rst_n), .clr(any_edge | stopped),
    .lim(quiet_lim), .cnt(quiet_cnt), .reached(quiet_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 sdr_mode <= 1'b0;
    else if (start_p || stop_p) sdr_mode <= 1'b0;
    else if (quiet_hit)         sdr_mode <= 1'b1;
  end

  // Stalled-read watchdog
  bcm_run_timer #(.CW(CW)) u_read (
    .clk(clk), .rst_n(rst_n), .clr(~read_active | scl_edge),
    .lim(read_lim), .cnt(rd_cnt), .reached(rd_hit)
  );

  assign read_abort = read_active & rd_hit;

  p_start_ends_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> !bus_free);
  p_sdr_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_p || stop_p) |=> !sdr_mode);
  p_sdr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sdr_mode && !start_p && !stop_p) |=> sdr_mode);
  p_scl_edge_rearms_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_edge && read_lim != '0) |=> !read_abort);
endmodule

// File: tb/test_bus_cond_monitor.sv
module test_bus_cond_monitor;
  localparam int  CW     = 8;
  localparam int  TOPC   = (1 << CW) - 1;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, rd_act = 1'b0, sel = 1'b0;
  logic [CW-1:0] f_lim = 8'd4, a_lim = 8'd10, il_lim = 8'd60, is_lim = 8'd30;
  logic [CW-1:0] q_lim = 8'd25, r_lim = 8'd15;
  logic start_p, rep_start_p, stop_p, bus_free, bus_avail, bus_idle;
  logic ibi_ok, hotjoin_ok, sdr_mode, read_abort;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  bus_cond_monitor #(.CW(CW)) i_bus_cond_monitor (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .read_active(rd_act),
    .free_lim(f_lim), .avail_lim(a_lim), .idle_lim_long(il_lim),
    .idle_lim_short(is_lim), .idle_short_sel(sel), .quiet_lim(q_lim),
    .read_lim(r_lim), .start_p(start_p), .rep_start_p(rep_start_p),
    .stop_p(stop_p), .bus_free(bus_free), .bus_avail(bus_avail),
    .bus_idle(bus_idle), .ibi_ok(ibi_ok), .hotjoin_ok(hotjoin_ok),
    .sdr_mode(sdr_mode), .read_abort(read_abort)
  );

  // Behavioural reference: queue of sampled line pairs {scl,sda}, newest first
  logic [1:0] hist[$];
  int  m_hi, m_quiet, m_rd;
  bit  m_stopped, m_sdr;

  function automatic int sat_inc(int v);
    return (v >= TOPC) ? TOPC : v + 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{2'b11, 2'b11, 2'b11};
      m_hi = 0; m_quiet = 0; m_rd = 0; m_stopped = 1; m_sdr = 0;
    end else begin
      logic [1:0] c, p;
      bit st, sp, e;
      c = hist[1]; p = hist[2];
      e  = (c != p);
      st = p[1] && c[1] && p[0] && !c[0];
      sp = p[1] && c[1] && !p[0] && c[0];
      if (st || sp) m_sdr = 0;
      else if (m_quiet >= q_lim) m_sdr = 1;
      m_quiet = (e || m_stopped) ? 0 : sat_inc(m_quiet);
      m_hi    = (e || c != 2'b11) ? 0 : sat_inc(m_hi);
      m_rd    = (!rd_act || c[1] != p[1]) ? 0 : sat_inc(m_rd);
      if (st) m_stopped = 0;
      else if (sp) m_stopped = 1;
      hist.push_front({scl, sda});
      void'(hist.pop_back());
    end
  end

  task automatic check(string tag, string name, logic got, logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s at %0t: got %b expected %b", tag, name, $time, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      logic [1:0] c, p;
      bit st, sp, fr, av, id;
      c = hist[1]; p = hist[2];
      st = p[1] && c[1] && p[0] && !c[0];
      sp = p[1] && c[1] && !p[0] && c[0];
      fr = m_stopped && (m_hi >= f_lim);
      av = fr && (m_hi >= a_lim);
      id = av && (m_hi >= (sel ? is_lim : il_lim));
      if (!rst_n) begin
        check("R5", "reset flags", |{start_p, stop_p, bus_free, bus_avail,
              bus_idle, sdr_mode, read_abort}, 1'b0);
      end else begin
        check("R1", "start_p", start_p, st);
        check("R1", "stop_p", stop_p, sp);
        check("R6", "rep_start_p", rep_start_p, st && !m_stopped);
        check("R2", "bus_free", bus_free, fr);
        check("R3", "bus_avail", bus_avail, av);
        check("R3", "ibi_ok", ibi_ok, av || (st && m_stopped));
        check("R4", "bus_idle", bus_idle, id);
        check("R4", "hotjoin_ok", hotjoin_ok, id);
        check("R7", "sdr_mode", sdr_mode, m_sdr);
        check("R8", "read_abort", read_abort, rd_act && (m_rd >= r_lim));
      end
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_start();
    sda = 1'b0; wait_cyc(3); scl = 1'b0; wait_cyc(3);
  endtask

  task automatic do_bit(logic b);
    sda = b; wait_cyc(2); scl = 1'b1; wait_cyc(3); scl = 1'b0; wait_cyc(2);
  endtask

  task automatic do_stop();
    sda = 1'b0; wait_cyc(2); scl = 1'b1; wait_cyc(3); sda = 1'b1; wait_cyc(2);
  endtask

  task automatic do_rstart();
    sda = 1'b1; wait_cyc(2); scl = 1'b1; wait_cyc(3); do_start();
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    // R5: levels rise from reset with no STOP on the lines
    wait_cyc(80);
    // R1 R6: plain start, bits, stop; R2 R3 grading after STOP
    do_start(); do_bit(1'b1); do_bit(1'b0); do_bit(1'b1); do_stop();
    wait_cyc(20);
    // Plain start before idle, then a repeated start (R6)
    do_start(); do_bit(1'b0); do_bit(1'b1); do_rstart(); do_bit(1'b1);
    // R8: read with running clock, then a stalled clock
    rd_act = 1'b1;
    do_bit(1'b1); do_bit(1'b0);
    wait_cyc(30);
    scl = 1'b1; wait_cyc(5); scl = 1'b0; wait_cyc(20);
    rd_act = 1'b0; wait_cyc(3);
    do_stop();
    // R4: reduced idle threshold
    sel = 1'b1; wait_cyc(70);
    sel = 1'b0; wait_cyc(70);
    // R7: quiet inside a transaction, edges keep the verdict, START clears
    do_start(); wait_cyc(40);
    scl = 1'b1; wait_cyc(5); scl = 1'b0; wait_cyc(5);
    do_rstart(); wait_cyc(40);
    do_stop(); wait_cyc(10);
    // R9: limit at counter ceiling, held without wrap
    il_lim = 8'hFF; wait_cyc(300);
    do_start(); do_stop(); wait_cyc(10);
    finish_run();
  end
endmodule